// File: doc/BRIEF.md
# Zero-Operand Stack Processor Core

A small sequencer core that runs a program of 9-bit words held in a synchronous program memory. There are no operand fields. A word whose top bit is clear carries an 8-bit constant that goes into the 16-bit top-of-stack register. A word whose top bit is set is an operation: arithmetic and logic, stack shuffling, an unconditional or a conditional jump, a subroutine call or return, or a byte transfer on the 8-bit I/O port. Wider constants are formed by placing literal words back to back. The first literal of a run is sign-extended. Each further literal shifts the value up by one byte and inserts its own byte at the bottom.

The core spends two clock cycles on each instruction. In the fetch cycle it drives the program counter onto the memory address. In the execute cycle it decodes the word that the memory returns and updates its state. Below the top-of-stack register sits an 8-entry circular data stack. A separate 4-entry circular stack holds return addresses. Jump and call targets come from the top of the stack. Results leave the core only through the output port. A one-cycle write strobe marks each output byte, and a one-cycle read strobe marks each input byte taken.

Top module: `stk_core`

## Requirements
- R1: A word with bit 8 clear is a literal. If the previous instruction was not a literal, the old top of stack is pushed and the top becomes the 8-bit payload sign-extended to 16 bits. The program counter then advances by one.
- R2: A literal that directly follows another literal pushes nothing. It shifts the top left by 8 bits and places its payload in the low byte, so only the last two bytes of a longer run remain.
- R3: Any word with bit 8 set ends a literal run. This includes NOP (0x100) and every undefined code from 0x10F to 0x1FF, none of which does anything else.
- R4: ADD 0x101, SUB 0x102, AND 0x103, OR 0x104 and XOR 0x105 combine the second entry (left operand) with the top (right operand). Each pops one entry and leaves the 16-bit result on top.
- R5: DUP 0x106 pushes a copy of the top. DROP 0x107 pops the top. SWAP 0x108 exchanges the top two entries.
- R6: JMP 0x109 loads the program counter from the low bits of the top and pops it. JZ 0x10A takes its target from the top and its condition from the second entry. It jumps only when the condition is zero and pops both entries in either case.
- R7: CALL 0x10B pushes the address of the following word onto the return stack, jumps to the top of the data stack and pops it. RET 0x10C jumps to the newest return address and pops it, so nested calls unwind in reverse order.
- R8: IN 0x10D pushes the zero-extended input byte and raises io_rd_o for exactly its execute cycle. OUT 0x10E places the low byte of the top on io_out_o, raises io_wr_o for exactly one cycle and pops. The two strobes are never high together.
- R9: The data stack keeps 8 entries below the top in a ring. A ninth push overwrites the oldest entry, and popping past the stored entries wraps around the ring.
- R10: While rst_ni is low, the program counter, the top of stack and every stack entry are zero, and both strobes are low.
- R11: Fetch and execute cycles alternate. pmem_addr_o holds its value through each execute cycle. io_wr_o rises in the fetch cycle that follows the execute edge of its OUT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pmem_addr_o | output | PC_W | Program memory address (program counter) |
| pmem_rdata_i | input | 9 | Program word, valid one cycle after its address |
| io_in_i | input | 8 | Input port byte |
| io_rd_o | output | 1 | Input strobe, high in the execute cycle of IN |
| io_out_o | output | 8 | Output port byte |
| io_wr_o | output | 1 | Output strobe, one cycle per OUT |

## Verification
After reset is released, the first execute cycle comes one edge later and the program counter advances on the edge after that. An OUT executed at that second edge raises io_wr_o in the fetch cycle that immediately follows it, so every output byte is due two cycles after its instruction word was addressed. The bench checks the address and strobe sequence cycle by cycle right after reset. For everything else it lets a scoreboard pair each io_wr_o pulse, sampled at the falling edge, with the next expected byte in program order. Values wider than a byte are confirmed inside the program: it subtracts a reference built from literals and branches with JZ to emit a pass or fail marker. After each program the bench waits a fixed number of cycles to catch missing or surplus bytes.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int unsigned WORD_W = 9;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [7:0] {
    OP_NOP  = 8'h00,
    OP_ADD  = 8'h01,
    OP_SUB  = 8'h02,
    OP_AND  = 8'h03,
    OP_OR   = 8'h04,
    OP_XOR  = 8'h05,
    OP_DUP  = 8'h06,
    OP_DROP = 8'h07,
    OP_SWAP = 8'h08,
    OP_JMP  = 8'h09,
    OP_JZ   = 8'h0A,
    OP_CALL = 8'h0B,
    OP_RET  = 8'h0C,
    OP_IN   = 8'h0D,
    OP_OUT  = 8'h0E
  } op_e;
endpackage

// File: rtl/stk_lifo.sv
// Circular stack; DEPTH must be a power of two.
module stk_lifo #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic         pop2_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] top_o,
  output logic [W-1:0] second_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0] ptr_q, ptr_m1, ptr_m2;
  logic [W-1:0]  mem_q [DEPTH];

  assign ptr_m1   = ptr_q - AW'(1);
  assign ptr_m2   = ptr_q - AW'(2);
  assign top_o    = mem_q[ptr_m1];
  assign second_o = mem_q[ptr_m2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i && pop_i) begin
      mem_q[ptr_m1] <= din_i;  // replace top
    end else if (push_i) begin
      mem_q[ptr_q] <= din_i;
      ptr_q        <= ptr_q + AW'(1);
    end else if (pop2_i) begin
      ptr_q <= ptr_m2;
    end else if (pop_i) begin
      ptr_q <= ptr_m1;
    end
  end
endmodule

// File: rtl/stk_alu.sv
module stk_alu
  import stk_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  op_e          op_i,
  input  logic [W-1:0] nos_i,
  input  logic [W-1:0] tos_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    case (op_i)
      OP_ADD:  res_o = nos_i + tos_i;
      OP_SUB:  res_o = nos_i - tos_i;
      OP_AND:  res_o = nos_i & tos_i;
      OP_OR:   res_o = nos_i | tos_i;
      OP_XOR:  res_o = nos_i ^ tos_i;
      default: res_o = tos_i;
    endcase
  end
endmodule

// File: rtl/stk_core.sv
module stk_core
  import stk_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned PC_W     = 8,
  parameter int unsigned DS_DEPTH = 8,
  parameter int unsigned RS_DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [PC_W-1:0]   pmem_addr_o,
  input  logic [WORD_W-1:0] pmem_rdata_i,
  input  logic [BYTE_W-1:0] io_in_i,
  output logic              io_rd_o,
  output logic [BYTE_W-1:0] io_out_o,
  output logic              io_wr_o
);
  localparam int unsigned EXT_W = DATA_W - BYTE_W;

  logic              exec_q;
  logic [PC_W-1:0]   pc_q, pc_d, pc_inc, tgt, rs_top, rs_second_unused;
  logic [DATA_W-1:0] t_q, t_d, nos, third, alu_y, ds_din;
  logic              run_q, run_d;
  logic              ds_push, ds_pop, ds_pop2, rs_push, rs_pop;
  logic [BYTE_W-1:0] out_q, out_d, imm;
  logic              wr_q, wr_d, is_lit;
  op_e               op;

  assign is_lit      = ~pmem_rdata_i[WORD_W-1];
  assign imm         = pmem_rdata_i[BYTE_W-1:0];
  assign op          = op_e'(imm);
  assign pc_inc      = pc_q + PC_W'(1);
  assign tgt         = t_q[PC_W-1:0];
  assign pmem_addr_o = pc_q;
  assign io_out_o    = out_q;
  assign io_wr_o     = wr_q;
  assign io_rd_o     = exec_q & ~is_lit & (op == OP_IN);

  stk_alu #(.W(DATA_W)) u_alu (
    .op_i (op),
    .nos_i(nos),
    .tos_i(t_q),
    .res_o(alu_y)
  );

  // entries below the top-of-stack register
  stk_lifo #(.W(DATA_W), .DEPTH(DS_DEPTH)) u_dstack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (ds_push),
    .pop_i   (ds_pop),
    .pop2_i  (ds_pop2),
    .din_i   (ds_din),
    .top_o   (nos),
    .second_o(third)
  );

  stk_lifo #(.W(PC_W), .DEPTH(RS_DEPTH)) u_rstack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rs_push),
    .pop_i   (rs_pop),
    .pop2_i  (1'b0),
    .din_i   (pc_inc),
    .top_o   (rs_top),
    .second_o(rs_second_unused)
  );

  always_comb begin
    t_d     = t_q;
    pc_d    = pc_q;
    run_d   = run_q;
    ds_push = 1'b0;
    ds_pop  = 1'b0;
    ds_pop2 = 1'b0;
    ds_din  = t_q;
    rs_push = 1'b0;
    rs_pop  = 1'b0;
    out_d   = out_q;
    wr_d    = 1'b0;
    if (exec_q) begin
      pc_d = pc_inc;
      if (is_lit) begin
        run_d = 1'b1;
        if (run_q) begin
          t_d = {t_q[DATA_W-BYTE_W-1:0], imm};
        end else begin
          ds_push = 1'b1;
          t_d     = {{EXT_W{imm[BYTE_W-1]}}, imm};
        end
      end else begin
        run_d = 1'b0;
        case (op)
          OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR: begin
            t_d    = alu_y;
            ds_pop = 1'b1;
          end
          OP_DUP: ds_push = 1'b1;
          OP_DROP: begin
            t_d    = nos;
            ds_pop = 1'b1;
          end
          OP_SWAP: begin
            t_d     = nos;
            ds_push = 1'b1;
            ds_pop  = 1'b1;
          end
          OP_JMP: begin
            pc_d   = tgt;
            t_d    = nos;
            ds_pop = 1'b1;
          end
          OP_JZ: begin
            if (nos == '0) pc_d = tgt;
            t_d     = third;
            ds_pop2 = 1'b1;
          end
          OP_CALL: begin
            rs_push = 1'b1;
            pc_d    = tgt;
            t_d     = nos;
            ds_pop  = 1'b1;
          end
          OP_RET: begin
            pc_d   = rs_top;
            rs_pop = 1'b1;
          end
          OP_IN: begin
            ds_push = 1'b1;
            t_d     = {{EXT_W{1'b0}}, io_in_i};
          end
          OP_OUT: begin
            out_d  = t_q[BYTE_W-1:0];
            wr_d   = 1'b1;
            t_d    = nos;
            ds_pop = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exec_q <= 1'b0;
      pc_q   <= '0;
      t_q    <= '0;
      run_q  <= 1'b0;
      out_q  <= '0;
      wr_q   <= 1'b0;
    end else begin
      exec_q <= ~exec_q;
      pc_q   <= pc_d;
      t_q    <= t_d;
      run_q  <= run_d;
      out_q  <= out_d;
      wr_q   <= wr_d;
    end
  end
endmodule

// File: rtl/stk_core_chk.sv
module stk_core_chk #(
  parameter int unsigned PC_W = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            exec_i,
  input logic [PC_W-1:0] pmem_addr_o,
  input logic [8:0]      pmem_rdata_i,
  input logic            io_rd_o,
  input logic            io_wr_o
);
  AST_RD_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_rd_o |=> !io_rd_o) else $error("rd strobe longer than one cycle"); // R8

  AST_WR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_wr_o |=> !io_wr_o) else $error("wr strobe longer than one cycle"); // R8

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({io_rd_o, io_wr_o})) else $error("rd and wr together"); // R8

  AST_WR_IN_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_wr_o |-> !exec_i) else $error("wr strobe in execute cycle"); // R11

  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i |-> $stable(pmem_addr_o)) else $error("address moved into execute"); // R11

  AST_LIT_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && !pmem_rdata_i[8]) |=> (pmem_addr_o == $past(pmem_addr_o) + PC_W'(1)))
    else $error("literal did not advance pc"); // R1

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RST_STATE: assert (pmem_addr_o == '0 && !io_wr_o && !io_rd_o)
        else $error("state not cleared in reset"); // R10
    end
  end
endmodule

bind stk_core stk_core_chk #(.PC_W(PC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .exec_i      (exec_q),
  .pmem_addr_o (pmem_addr_o),
  .pmem_rdata_i(pmem_rdata_i),
  .io_rd_o     (io_rd_o),
  .io_wr_o     (io_wr_o)
);

// File: tb/stk_core_test.sv
module stk_core_test;
  localparam int K_NOP = 8'h00, K_ADD = 8'h01, K_SUB = 8'h02, K_AND = 8'h03, K_OR = 8'h04;
  localparam int K_XOR = 8'h05, K_DUP = 8'h06, K_DROP = 8'h07, K_SWAP = 8'h08, K_JMP = 8'h09;
  localparam int K_JZ = 8'h0A, K_CALL = 8'h0B, K_RET = 8'h0C, K_IN = 8'h0D, K_OUT = 8'h0E;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b1;
  logic [7:0] pmem_addr;
  logic [8:0] rdata = 9'h100;
  logic [7:0] io_in = 8'h00;
  logic       io_rd, io_wr;
  logic [7:0] io_out;
  logic [8:0] rom [256];

  int total = 0, bad = 0, ap = 0, rd_cnt = 0;
  logic [7:0] expq[$];
  string      tagq[$];

  always #5 clk = ~clk;
  always @(posedge clk) rdata <= rom[pmem_addr];

  stk_core uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .pmem_addr_o (pmem_addr),
    .pmem_rdata_i(rdata),
    .io_in_i     (io_in),
    .io_rd_o     (io_rd),
    .io_out_o    (io_out),
    .io_wr_o     (io_wr)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni) begin
      if (io_rd) rd_cnt++;
      if (io_wr) begin
        if (expq.size() == 0) chk(1'b0, "unexpected output byte", int'(io_out), 0);
        else begin
          logic [7:0] e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          chk(io_out == e, t, int'(io_out), int'(e));
        end
      end
    end
  end

  task automatic emit(logic [8:0] w);
    rom[ap] = w;
    ap++;
  endtask
  task automatic lit(int b);  emit({1'b0, 8'(b)}); endtask
  task automatic op(int c);   emit({1'b1, 8'(c)}); endtask
  task automatic want(int b, string tag);
    expq.push_back(8'(b));
    tagq.push_back(tag);
  endtask
  task automatic halt();
    op(K_NOP);
    lit(ap);
    op(K_JMP);
  endtask
  // top of stack must be zero: program emits A5 on pass, 5A on fail
  task automatic check_zero(string tag);
    int p;
    op(K_NOP);
    p = ap;
    lit(p + 6); op(K_JZ);
    lit(8'h5A); op(K_OUT);
    lit(p + 8); op(K_JMP);
    lit(8'hA5); op(K_OUT);
    want(8'hA5, tag);
  endtask
  task automatic clear_prog();
    for (int i = 0; i < 256; i++) rom[i] = 9'h100;
    ap = 0;
  endtask

  task automatic start();
    @(negedge clk);
    rst_ni = 1'b0;
    rd_cnt = 0;
    repeat (3) begin
      @(negedge clk);
      chk(pmem_addr == 0 && !io_wr && !io_rd, "R10 reset state", int'({io_wr, io_rd, pmem_addr}), 0);
    end
    rst_ni = 1'b1;
  endtask

  task automatic finish(string tag);
    for (int i = 0; i < 4000 && expq.size() != 0; i++) @(negedge clk);
    repeat (40) @(negedge clk);
    while (expq.size() != 0) begin
      chk(1'b0, {tag, " missing output ", tagq.pop_front()}, 0, int'(expq.pop_front()));
    end
  endtask

  initial begin
    #1_500_000;
    chk(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1 rst_ni = 1'b0;

    // R10 / R11: reset contents and fetch/execute timing
    clear_prog();
    op(K_OUT); op(K_DROP); op(K_OUT); halt();
    want(8'h00, "R10 top zero after reset");
    want(8'h00, "R10 stack entry zero after reset");
    start();
    @(negedge clk); chk(pmem_addr == 0 && !io_wr, "R11 first execute cycle", int'(pmem_addr), 0);
    @(negedge clk); chk(pmem_addr == 1 && io_wr,  "R11 wr after execute edge", int'({io_wr, pmem_addr}), 9'h101);
    @(negedge clk); chk(pmem_addr == 1 && !io_wr, "R11 address held, wr one cycle", int'({io_wr, pmem_addr}), 1);
    @(negedge clk); chk(pmem_addr == 2, "R11 second instruction fetch", int'(pmem_addr), 2);
    finish("R10");

    // R1 / R2: literal building
    clear_prog();
    lit(8'h80); op(K_OUT); want(8'h80, "R1 literal low byte");
    lit(8'h80); op(K_NOP); lit(8'hFF); lit(8'h80); op(K_SUB);
    check_zero("R1 negative sign extension");
    op(K_NOP); lit(8'h7F); op(K_NOP); lit(8'h00); lit(8'h7F); op(K_SUB);
    check_zero("R1 positive sign extension");
    op(K_NOP); lit(8'h12); lit(8'h34); lit(8'h56); op(K_OUT); want(8'h56, "R2 last byte at bottom");
    lit(8'h12); lit(8'h34); lit(8'h56); op(K_NOP); lit(8'h34); lit(8'h56); op(K_SUB);
    check_zero("R2 oldest byte shifted out");
    halt();
    start(); finish("R1");

    // R3: run termination, NOP and undefined codes
    clear_prog();
    lit(8'h05); op(K_NOP); lit(8'h03); op(K_ADD); op(K_OUT); want(8'h08, "R3 NOP ends run");
    lit(8'h05); lit(8'h03); op(K_OUT); want(8'h03, "R3 chained run without break");
    lit(8'h09); op(8'hF0); lit(8'h02); op(K_ADD); op(K_OUT); want(8'h0B, "R3 undefined code as NOP");
    halt();
    start(); finish("R3");

    // R4: arithmetic and logic
    clear_prog();
    lit(8'h07); op(K_NOP); lit(8'h03); op(K_SUB); op(K_OUT); want(8'h04, "R4 SUB");
    lit(8'h03); op(K_NOP); lit(8'h05); op(K_SUB); op(K_OUT); want(8'hFE, "R4 SUB negative");
    lit(8'h0C); op(K_NOP); lit(8'h0A); op(K_AND); op(K_OUT); want(8'h08, "R4 AND");
    lit(8'h0C); op(K_NOP); lit(8'h0A); op(K_OR);  op(K_OUT); want(8'h0E, "R4 OR");
    lit(8'h0C); op(K_NOP); lit(8'h0A); op(K_XOR); op(K_OUT); want(8'h06, "R4 XOR");
    lit(8'h0C); op(K_NOP); lit(8'h0A); op(K_ADD); op(K_OUT); want(8'h16, "R4 ADD");
    halt();
    start(); finish("R4");

    // R5: stack shuffles
    clear_prog();
    lit(8'h01); op(K_NOP); lit(8'h02); op(K_SWAP); op(K_OUT); op(K_OUT);
    want(8'h01, "R5 SWAP top"); want(8'h02, "R5 SWAP second");
    lit(8'h09); op(K_DUP); op(K_ADD); op(K_OUT); want(8'h12, "R5 DUP");
    lit(8'h03); op(K_NOP); lit(8'h04); op(K_DROP); op(K_OUT); want(8'h03, "R5 DROP");
    halt();
    start(); finish("R5");

    // R6: jumps
    clear_prog();
    begin
      int p;
      p = ap;
      lit(p + 4); op(K_JMP); lit(8'h5A); op(K_OUT); lit(8'h33); op(K_OUT);
      want(8'h33, "R6 JMP");
      p = ap;
      lit(8'h00); op(K_NOP); lit(p + 6); op(K_JZ); lit(8'h5A); op(K_OUT); lit(8'h44); op(K_OUT);
      want(8'h44, "R6 JZ taken");
      p = ap;
      lit(8'h77); op(K_NOP); lit(8'h01); op(K_NOP); lit(p + 9); op(K_JZ); op(K_OUT);
      lit(p + 11); op(K_JMP); lit(8'h5A); op(K_OUT);
      want(8'h77, "R6 JZ not taken pops both");
    end
    halt();
    start(); finish("R6");

    // R7: nested call and return
    clear_prog();
    lit(7); op(K_CALL); lit(8'h22); op(K_OUT); halt();
    lit(8'h11); op(K_OUT); lit(14); op(K_CALL); lit(8'h33); op(K_OUT); op(K_RET);
    lit(8'h66); op(K_OUT); op(K_RET);
    want(8'h11, "R7 enter outer"); want(8'h66, "R7 enter inner");
    want(8'h33, "R7 return to outer"); want(8'h22, "R7 return to main");
    start(); finish("R7");

    // R8: port transfers
    clear_prog();
    io_in = 8'hC3;
    op(K_IN); op(K_OUT); want(8'hC3, "R8 IN byte");
    op(K_IN); op(K_NOP); lit(8'h00); lit(8'hC3); op(K_SUB);
    check_zero("R8 IN zero extension");
    op(K_NOP); lit(8'h01); lit(8'hAB); op(K_OUT); want(8'hAB, "R8 OUT low byte");
    halt();
    start(); finish("R8");
    chk(rd_cnt == 2, "R8 one rd cycle per IN", rd_cnt, 2);

    // R9: ring wrap of the data stack
    clear_prog();
    for (int v = 1; v <= 9; v++) begin
      lit(v); op(K_NOP);
    end
    for (int k = 0; k < 10; k++) op(K_OUT);
    for (int v = 9; v >= 1; v--) want(v, "R9 pop order");
    want(8'h08, "R9 wrap after overwrite");
    halt();
    start(); finish("R9");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule